// File: doc/BRIEF.md
# Fixed-Frame Two-Wire Message Receiver

This block is a receive-only target on a shared two-wire serial bus (I2C) where several nodes may drive transfers. It oversamples the clock and data lines through two-flop synchronisers and detects start, repeated start and stop conditions. It then decodes the first byte as a 7-bit target address followed by a direction flag. A write addressed to the locally configured address, or to the all-nodes address 00h, is acknowledged. The block then collects a message of exactly eight data bytes.

Each data byte is acknowledged by pulling SDA low for the ninth clock. When the eighth byte has been acknowledged, the message appears on parallel outputs split into destination, source, message code and a five-byte payload. A single-cycle strobe marks it. A message that is cut short is dropped. A supervision counter returns the receiver to idle if SCL stops toggling in the middle of a transfer. Controller operation, arbitration, clock stretching and read transfers are not part of this block.

Top module: `i2c_frame_rx`

## Requirements
- R1: After reset, `sda_oe` and `frame_valid` are 0.
- R2: The first byte after a start or repeated start is taken MSB first. Bits [7:1] are the address and bit 0 is the direction, where 0 means write. A write whose address equals `local_addr` is acknowledged: `sda_oe` is 1 during the ninth SCL high phase.
- R3: A write to address 00h is acknowledged and received in the same way as a write to `local_addr`.
- R4: An address byte with direction 1, or with an address that matches neither `local_addr` nor 00h, is not acknowledged. No later byte is acknowledged until the next start or stop.
- R5: `sda_oe` is asserted only in the acknowledge slot. It goes high after the SCL fall that ends the eighth bit and goes low after the SCL fall that ends the ninth bit. It is never driven outside that slot.
- R6: Data bytes 0 to 7 are each acknowledged. After the SCL fall that ends the eighth data byte's acknowledge, `frame_valid` is high for exactly one clock. At that point `frame_dst` holds byte 0, `frame_src` holds byte 1 and `frame_code` holds byte 2. `frame_payload[7:0]` holds byte 3, and so on up to `frame_payload[39:32]`, which holds byte 7.
- R7: Bytes that follow the eighth data byte are not acknowledged and give no further `frame_valid` until a new start.
- R8: A message ended by a stop before eight data bytes have arrived produces no `frame_valid`.
- R9: A repeated start discards any partial message and begins a new address phase. A complete message that follows it is received normally.
- R10: If no SCL edge is seen for `TIMEOUT` clocks while a transfer is active, the receiver returns to idle and releases `sda_oe`, even during an acknowledge slot. It acknowledges nothing more until a new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| local_addr | input | 7 | Configured 7-bit target address |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| sda_oe | output | 1 | When 1, the pad pulls SDA low |
| frame_valid | output | 1 | One-clock strobe: a complete message is on the outputs |
| frame_dst | output | 8 | Data byte 0, destination |
| frame_src | output | 8 | Data byte 1, source |
| frame_code | output | 8 | Data byte 2, message code |
| frame_payload | output | 40 | Data bytes 3 to 7, byte 3 in the low bits |

## Verification
A wrong receive state shows up at the ports in one of two ways: a missing or extra pull on SDA, or a strobe with wrong or missing contents. An address or byte-count error appears at the ninth clock of the affected byte, which is roughly three system clocks after the SCL fall. That is why `sda_oe` is compared against the allowed acknowledge window on every clock, and is sampled mid-way through each ninth SCL high phase. A miscounted byte index appears either as a strobe one byte early or late, or as wrong field contents. Each strobe is therefore matched against the exact message the bench sent. A watchdog that fails to fire shows up as SDA still held low after a long stall with SCL high.

// File: rtl/i2c_frame_rx.sv
module i2c_frame_rx #(
  parameter int NBYTES  = 8,
  parameter int TIMEOUT = 4096
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [6:0]                local_addr,
  input  logic                      scl_i,
  input  logic                      sda_i,
  output logic                      sda_oe,
  output logic                      frame_valid,
  output logic [7:0]                frame_dst,
  output logic [7:0]                frame_src,
  output logic [7:0]                frame_code,
  output logic [(NBYTES-3)*8-1:0]   frame_payload
);
  localparam int IW = $clog2(NBYTES + 1);
  localparam int WW = $clog2(TIMEOUT);

  typedef enum logic [1:0] {S_IDLE, S_ADDR, S_DATA, S_SKIP} st_t;

  st_t                  st;
  logic [2:0]           scl_p, sda_p;
  logic [3:0]           bcnt;
  logic [7:0]           sh;
  logic [IW-1:0]        idx;
  logic [NBYTES*8-1:0]  buf_q;
  logic [WW-1:0]        wd;

  wire scl_s = scl_p[1];
  wire scl_q = scl_p[2];
  wire sda_s = sda_p[1];
  wire sda_q = sda_p[2];

  wire scl_rise = scl_s & ~scl_q;
  wire scl_fall = ~scl_s & scl_q;
  wire start    = scl_s & scl_q & sda_q & ~sda_s;
  wire stop     = scl_s & scl_q & ~sda_q & sda_s;
  wire addr_ok  = ~sh[0] & ((sh[7:1] == local_addr) | (sh[7:1] == 7'd0));
  wire wd_fire  = (st != S_IDLE) && (wd == WW'(TIMEOUT - 1)) &&
                  !(scl_rise | scl_fall | start | stop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      bcnt        <= '0;
      sh          <= '0;
      idx         <= '0;
      buf_q       <= '0;
      wd          <= '0;
      sda_oe      <= 1'b0;
      frame_valid <= 1'b0;
    end else begin
      frame_valid <= 1'b0;
      if (start) begin
        st     <= S_ADDR;
        bcnt   <= '0;
        idx    <= '0;
        wd     <= '0;
        sda_oe <= 1'b0;
      end else if (stop || wd_fire) begin
        st     <= S_IDLE;
        bcnt   <= '0;
        wd     <= '0;
        sda_oe <= 1'b0;
      end else if (st != S_IDLE) begin
        wd <= (scl_rise | scl_fall) ? '0 : wd + 1'b1;
        if (scl_rise && bcnt < 4'd8) begin
          sh   <= {sh[6:0], sda_s};
          bcnt <= bcnt + 1'b1;
        end else if (scl_rise && bcnt == 4'd8) begin
          bcnt <= 4'd9;
        end else if (scl_fall && bcnt == 4'd8) begin
          if (st == S_ADDR) begin
            if (addr_ok) sda_oe <= 1'b1;
            else         st     <= S_SKIP;
          end else if (st == S_DATA) begin
            buf_q[idx*8 +: 8] <= sh;
            idx               <= idx + 1'b1;
            sda_oe            <= 1'b1;
          end
        end else if (scl_fall && bcnt == 4'd9) begin
          sda_oe <= 1'b0;
          bcnt   <= '0;
          if (st == S_ADDR) begin
            st <= S_DATA;
          end else if (st == S_DATA && idx == IW'(NBYTES)) begin
            frame_valid <= 1'b1;
            st          <= S_SKIP;
          end
        end
      end
    end
  end

  assign frame_dst     = buf_q[7:0];
  assign frame_src     = buf_q[15:8];
  assign frame_code    = buf_q[23:16];
  assign frame_payload = buf_q[NBYTES*8-1:24];

endmodule

// File: rtl/i2c_frame_rx_chk.sv
module i2c_frame_rx_chk #(
  parameter int IW = 4,
  parameter int NBYTES = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_s,
  input logic          sda_oe,
  input logic          frame_valid,
  input logic          wd_fire,
  input logic [1:0]    st,
  input logic [IW-1:0] idx,
  input logic [7:0]    sh,
  input logic [6:0]    local_addr
);
  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |=> !frame_valid);

  p_valid_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_valid |-> (idx == IW'(NBYTES)) && (st == 2'd3));

  p_oe_scl_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(sda_oe) && !$past(wd_fire)) |-> !$past(scl_s));

  p_oe_active_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> (st == 2'd1 || st == 2'd2));

  p_addr_match_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(sda_oe) && st == 2'd1) |->
      (!sh[0] && (sh[7:1] == local_addr || sh[7:1] == 7'd0)));

  p_wd_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wd_fire |=> (st == 2'd0) && !sda_oe);
endmodule

bind i2c_frame_rx i2c_frame_rx_chk #(.IW(IW), .NBYTES(NBYTES)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe),
  .frame_valid(frame_valid), .wd_fire(wd_fire), .st(st), .idx(idx),
  .sh(sh), .local_addr(local_addr)
);

// File: tb/i2c_frame_rx_tb.sv
module i2c_frame_rx_tb;
  localparam int CLK_P = 10;
  localparam int H     = 6;
  localparam int TO    = 300;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:0]  local_addr = 7'h41;
  logic        m_scl = 1'b1, m_sda = 1'b1;
  logic        sda_oe, frame_valid;
  logic [7:0]  frame_dst, frame_src, frame_code;
  logic [39:0] frame_payload;

  int n_chk = 0, n_fail = 0, nframes = 0;
  bit allow = 1'b0, prev_valid = 1'b0, done = 1'b0;
  logic [63:0] exp_q[$];

  always #(CLK_P/2) clk = ~clk;

  i2c_frame_rx #(.NBYTES(8), .TIMEOUT(TO)) u_dut (
    .clk(clk), .rst_n(rst_n), .local_addr(local_addr),
    .scl_i(m_scl), .sda_i(m_sda & ~sda_oe),
    .sda_oe(sda_oe), .frame_valid(frame_valid),
    .frame_dst(frame_dst), .frame_src(frame_src),
    .frame_code(frame_code), .frame_payload(frame_payload)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check(!(sda_oe && !allow), "R5 sda_oe outside ack slot", 64'(sda_oe), 64'(0));
      if (frame_valid) begin
        nframes++;
        check(!prev_valid, "R6 strobe longer than one clock", 64'(1), 64'(0));
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected frame strobe",
                {frame_payload, frame_code, frame_src, frame_dst}, 64'(0));
        end else begin
          logic [63:0] e;
          e = exp_q.pop_front();
          check({frame_payload, frame_code, frame_src, frame_dst} == e, "R6 frame contents",
                {frame_payload, frame_code, frame_src, frame_dst}, e);
        end
      end
      prev_valid = frame_valid;
    end
  end

  task automatic bus_start();
    m_sda = 1'b0; tick(H);
    m_scl = 1'b0; tick(H);
  endtask

  task automatic bus_rstart();
    m_sda = 1'b1; tick(H);
    m_scl = 1'b1; tick(H);
    m_sda = 1'b0; tick(H);
    m_scl = 1'b0; tick(H);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; tick(H);
    m_scl = 1'b1; tick(H);
    m_sda = 1'b1; tick(2*H);
  endtask

  task automatic send_bits(input logic [7:0] b, input bit ack_exp);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; tick(H);
      m_scl = 1'b1; tick(H);
      if (i == 0) allow = ack_exp;
      m_scl = 1'b0;
    end
    m_sda = 1'b1; tick(H);
    m_scl = 1'b1;
  endtask

  task automatic send_byte(input logic [7:0] b, input bit ack_exp, input string req);
    send_bits(b, ack_exp);
    tick(H/2);
    check(sda_oe == ack_exp, req, 64'(sda_oe), 64'(ack_exp));
    tick(H - H/2);
    m_scl = 1'b0; tick(4);
    allow = 1'b0; tick(H - 4);
  endtask

  task automatic send_msg(input logic [7:0] abyte, input bit aack, input logic [63:0] d,
                          input int n, input string req);
    if (aack && n >= 8) exp_q.push_back(d);
    send_byte(abyte, aack, req);
    for (int k = 0; k < n; k++)
      send_byte(d[8*k +: 8], aack && (k < 8), req);
  endtask

  initial begin
    int nf;
    tick(5);
    rst_n = 1'b1;
    tick(2);
    check(sda_oe == 1'b0, "R1 sda_oe after reset", 64'(sda_oe), 64'(0));
    check(frame_valid == 1'b0, "R1 frame_valid after reset", 64'(frame_valid), 64'(0));

    // R2: own address, full message
    nf = nframes;
    bus_start();
    send_msg({7'h41, 1'b0}, 1'b1, 64'hEEEE_0102_1555_0141, 8, "R2 own address ack");
    bus_stop();
    check(nframes == nf + 1, "R6 one frame for own address", 64'(nframes - nf), 64'(1));

    // R3: general call
    nf = nframes;
    bus_start();
    send_msg(8'h00, 1'b1, 64'h8877_6655_4433_2211, 8, "R3 general call ack");
    bus_stop();
    check(nframes == nf + 1, "R3 frame for general call", 64'(nframes - nf), 64'(1));

    // R4: read request to own address
    nf = nframes;
    bus_start();
    send_msg({7'h41, 1'b1}, 1'b0, 64'h0000_0000_0000_A55A, 2, "R4 read not acked");
    bus_stop();
    // R4: foreign address
    bus_start();
    send_msg({7'h42, 1'b0}, 1'b0, 64'h0706_0504_0302_0100, 8, "R4 foreign address not acked");
    bus_stop();
    check(nframes == nf, "R4 no frame for rejected address", 64'(nframes - nf), 64'(0));

    // R8: truncated by stop
    nf = nframes;
    bus_start();
    send_msg({7'h41, 1'b0}, 1'b1, 64'h0000_00CC_BBAA_9988, 5, "R8 partial bytes acked");
    bus_stop();
    check(nframes == nf, "R8 no frame after short message", 64'(nframes - nf), 64'(0));

    // R7: extra bytes after eighth
    nf = nframes;
    bus_start();
    send_msg({7'h41, 1'b0}, 1'b1, 64'hF0E1_D2C3_B4A5_9687, 8, "R7 first eight acked");
    send_byte(8'h5A, 1'b0, "R7 ninth byte not acked");
    send_byte(8'hA5, 1'b0, "R7 tenth byte not acked");
    bus_stop();
    check(nframes == nf + 1, "R7 single frame despite extra bytes", 64'(nframes - nf), 64'(1));

    // R9: repeated start
    nf = nframes;
    bus_start();
    send_msg({7'h41, 1'b0}, 1'b1, 64'h0000_0000_0033_2211, 3, "R9 before restart");
    bus_rstart();
    send_msg({7'h41, 1'b0}, 1'b1, 64'h1357_9BDF_2468_ACE0, 8, "R9 after restart");
    bus_stop();
    check(nframes == nf + 1, "R9 only post-restart frame", 64'(nframes - nf), 64'(1));

    // R2: reconfigured address
    local_addr = 7'h7F;
    tick(4);
    nf = nframes;
    bus_start();
    send_msg({7'h41, 1'b0}, 1'b0, 64'h0, 2, "R2 old address no longer acked");
    bus_stop();
    bus_start();
    send_msg({7'h7F, 1'b0}, 1'b1, 64'h7F7F_7F7F_5501_407F, 8, "R2 new address ack");
    bus_stop();
    check(nframes == nf + 1, "R2 frame after reconfiguration", 64'(nframes - nf), 64'(1));

    // R10: stall during ack slot
    nf = nframes;
    bus_start();
    send_msg({7'h7F, 1'b0}, 1'b1, 64'h0000_0000_0000_2211, 2, "R10 bytes before stall");
    send_bits(8'h33, 1'b1);
    tick(H/2);
    check(sda_oe == 1'b1, "R10 ack held before stall", 64'(sda_oe), 64'(1));
    tick(TO + 20);
    check(sda_oe == 1'b0, "R10 sda released after timeout", 64'(sda_oe), 64'(1'b0));
    m_scl = 1'b0; tick(H);
    allow = 1'b0;
    send_byte(8'h44, 1'b0, "R10 byte after timeout not acked");
    bus_stop();
    check(nframes == nf, "R10 no frame after timeout", 64'(nframes - nf), 64'(0));
    bus_start();
    send_msg({7'h7F, 1'b0}, 1'b1, 64'h0102_0304_0506_0708, 8, "R10 recovery frame");
    bus_stop();
    check(nframes == nf + 1, "R10 frame after recovery", 64'(nframes - nf), 64'(1));
    check(exp_q.size() == 0, "R6 all expected frames delivered", 64'(exp_q.size()), 64'(0));

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule